// File: doc/BRIEF.md
# Stochastic Stream Edge Re-randomizer

Stochastic decoders carry probabilities as random bit streams. When a decoding node has no fresh information, it repeats its previous output and its stream stops switching. A node caught this way can latch a whole loop of neighbours into a fixed state, and this happens most often at high signal-to-noise ratio. This block sits on one edge, such as a state-metric stream or a stream that feeds the extrinsic output, and removes that correlation. It keeps a short history of the bits the upstream node produced while it was regenerative. While the upstream node signals a hold, the block replays a randomly chosen bit from that history, so the edge keeps the statistics of recent fresh bits.

Every beat carries one stream bit and a flag. A high flag means the bit is freshly generated, and the bit is passed straight through and pushed into the history. A low flag means the node is holding, and the block outputs the history slot selected by a random address that an external source supplies with the beat. After reset the history holds an alternating pattern, so early hold beats replay a density near one half. Beats use a valid/ready handshake with no storage at the block's edge. A beat transfers when `in_valid` and `out_ready` are both high. `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`, in the same cycle, so downstream back-pressure stalls the upstream node directly. When the block stalls, the history does not change.

Top module: `em_rerandomizer`

## Requirements
- R1: After reset, history slot k holds 0 when k is even and 1 when k is odd. Slot 0 is the newest position and slot DEPTH-1 the oldest (DEPTH = 32 by default).
- R2: On a transferring beat with `in_regen` = 1, `out_bit` equals `in_bit` in the same cycle.
- R3: On a transferring beat with `in_regen` = 0, `out_bit` equals the content of history slot `rand_addr` in the same cycle.
- R4: A transferring beat with `in_regen` = 1 writes `in_bit` into slot 0 at the next clock edge. Every slot k > 0 takes the old content of slot k-1, and the old content of slot DEPTH-1 is dropped.
- R5: A transferring beat with `in_regen` = 0 leaves every history slot unchanged.
- R6: A cycle with no transfer (`in_valid` = 0 or `out_ready` = 0) leaves every history slot unchanged, whatever the values of `in_regen` and `in_bit`.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.
- R8: For a Bernoulli input stream in which one beat in three is a hold, the fraction of ones on the output stays within 0.06 of the fraction of ones among the regenerative input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Block accepts the beat (equals `out_ready`) |
| in_bit | input | 1 | Stream bit from the upstream node |
| in_regen | input | 1 | 1 = regenerative bit, 0 = node in hold |
| rand_addr | input | 5 | Random history slot selector, used on hold beats |
| out_valid | output | 1 | Re-randomized beat present (equals `in_valid`) |
| out_ready | input | 1 | Downstream accepts the beat |
| out_bit | output | 1 | Re-randomized stream bit |

## Verification
The checker tests the handshake mirroring, the pass-through of regenerative bits, the choice of the addressed slot on hold beats, the one-slot shift after a regenerative transfer, and the frozen history on hold and stall cycles, all on every cycle. The bench reads the whole history at the ports through hold beats that sweep every address. This shows the reset pattern and confirms that holds and stalls left the stored bits intact. Only the bench's long scenario, with a biased random stream and forced holds, can show the statistical result that the output density follows the input density.

// File: rtl/em_pkg.sv
package em_pkg;

  typedef enum logic {
    EM_HOLD  = 1'b0,
    EM_REGEN = 1'b1
  } em_mode_e;

  // Reset content of a history slot: alternating, even slots 0
  function automatic logic em_reset_bit(input int slot);
    return (slot % 2) == 1;
  endfunction

endpackage

// File: rtl/em_history.sv
module em_history #(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             new_bit,
  output logic [DEPTH-1:0] slots
);
  import em_pkg::*;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      logic nxt;
      if (k == 0) begin : g_head
        assign nxt = new_bit;
      end else begin : g_body
        assign nxt = slots[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        slots[k] <= em_reset_bit(k);
        else if (shift_en) slots[k] <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/em_select.sv
module em_select #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  slots,
  input  logic [ADDR_W-1:0] addr,
  input  em_pkg::em_mode_e  mode,
  input  logic              live_bit,
  output logic              sel_bit
);
  import em_pkg::*;

  logic replay_bit;

  always_comb begin
    replay_bit = slots[0];
    for (int k = 0; k < DEPTH; k++) begin
      if (addr == ADDR_W'(k)) replay_bit = slots[k];
    end
  end

  assign sel_bit = (mode == EM_REGEN) ? live_bit : replay_bit;

endmodule

// File: rtl/em_rerandomizer.sv
module em_rerandomizer #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_regen,
  input  logic [ADDR_W-1:0] rand_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit
);
  import em_pkg::*;

  logic             fire;
  logic             push;
  em_mode_e         mode;
  logic [DEPTH-1:0] hist_q;

  assign fire      = in_valid & out_ready;
  assign mode      = in_regen ? EM_REGEN : EM_HOLD;
  assign push      = fire & (mode == EM_REGEN);
  assign in_ready  = out_ready;
  assign out_valid = in_valid;

  em_history #(.DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (push),
    .new_bit  (in_bit),
    .slots    (hist_q)
  );

  em_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sel (
    .slots    (hist_q),
    .addr     (rand_addr),
    .mode     (mode),
    .live_bit (in_bit),
    .sel_bit  (out_bit)
  );

endmodule

// File: rtl/em_rerandomizer_chk.sv
module em_rerandomizer_chk #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_bit,
  input logic              in_regen,
  input logic [ADDR_W-1:0] rand_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_bit,
  input logic [DEPTH-1:0]  hist
);

  AST_HANDSHAKE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)); // R7

  AST_REGEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && in_regen) |-> (out_bit == in_bit)); // R2

  AST_HOLD_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !in_regen) |-> (out_bit == hist[rand_addr])); // R3

  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && in_regen) |=> (hist[0] == $past(in_bit))); // R4

  AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && in_regen) |=>
      (hist[DEPTH-1:1] == $past(hist[DEPTH-2:0]))); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !in_regen) |=> $stable(hist)); // R5

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |=> $stable(hist)); // R6

endmodule

bind em_rerandomizer em_rerandomizer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bit    (in_bit),
  .in_regen  (in_regen),
  .rand_addr (rand_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .hist      (hist_q)
);

// File: tb/em_rerandomizer_test.sv
module em_rerandomizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int AW         = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_regen = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] rand_addr = '0;
  logic in_ready, out_valid, out_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic model [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  em_rerandomizer #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_regen(in_regen), .rand_addr(rand_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One cycle: drive after the falling edge, sample mid low phase, then update model
  task automatic beat(input logic v, input logic rdy, input logic b,
                      input logic rg, input logic [AW-1:0] a, output logic ob);
    @(negedge clk);
    in_valid = v; out_ready = rdy; in_bit = b; in_regen = rg; rand_addr = a;
    #(CLK_PERIOD/4);
    ob = out_bit;
    check(out_valid == v && in_ready == rdy, "R7", {out_valid, in_ready}, {v, rdy});
    @(posedge clk);
    if (v && rdy && rg) begin
      for (int k = DEPTH-1; k > 0; k--) model[k] = model[k-1];
      model[0] = b;
    end
  endtask

  // Read every slot through hold beats and compare with the model
  task automatic sweep(input string req);
    logic ob;
    for (int k = 0; k < DEPTH; k++) begin
      beat(1'b1, 1'b1, ~model[k], 1'b0, AW'(k), ob);
      check(ob == model[k], req, ob, model[k]);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < DEPTH; k++) model[k] = (k % 2 == 1);
    sweep("R1");
  endtask

  task automatic t_regen_pass();
    logic ob;
    for (int i = 0; i < 40; i++) begin
      step_lfsr();
      beat(1'b1, 1'b1, lfsr[0], 1'b1, lfsr[5:1], ob);
      check(ob == lfsr[0], "R2", ob, lfsr[0]);
    end
    sweep("R4");
  endtask

  task automatic t_hold_frozen();
    logic ob;
    for (int i = 0; i < 50; i++) begin
      step_lfsr();
      beat(1'b1, 1'b1, lfsr[3], 1'b0, lfsr[8:4], ob);
      check(ob == model[lfsr[8:4]], "R3", ob, model[lfsr[8:4]]);
    end
    sweep("R5");
  endtask

  task automatic t_stall();
    logic ob;
    for (int i = 0; i < 20; i++) begin
      step_lfsr();
      beat(1'b0, lfsr[2], lfsr[0], 1'b1, lfsr[7:3], ob);
      beat(1'b1, 1'b0, lfsr[1], 1'b1, lfsr[7:3], ob);
    end
    sweep("R6");
  endtask

  task automatic t_density();
    logic ob;
    longint in_ones = 0, in_tot = 0, out_ones = 0, out_tot = 0, lhs, rhs;
    for (int i = 0; i < 3000; i++) begin
      logic b, rg;
      step_lfsr();
      b  = (lfsr[1:0] != 2'b00);
      rg = (i % 3) != 2;
      beat(1'b1, 1'b1, b, rg, lfsr[10:6], ob);
      if (rg) begin in_tot++; in_ones += b; end
      out_tot++; out_ones += ob;
    end
    lhs = out_ones * in_tot - in_ones * out_tot;
    if (lhs < 0) lhs = -lhs;
    rhs = (6 * in_tot * out_tot) / 100;
    check(lhs <= rhs, "R8", int'((out_ones * 1000) / out_tot), int'((in_ones * 1000) / in_tot));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regen_pass();
    t_hold_frozen();
    t_stall();
    t_density();
    done = 1'b1;
    report();
  end

endmodule